// File: doc/BRIEF.md
# Banked UART Register Address Decoder

This block sits between a CPU bus and the rest of a UART. It takes a 3-bit register address with read and write enables and turns them into strobes and read data. Eight addresses reach seventeen registers. The line control register, which this block holds, chooses which of three banks the addresses map to.

The block holds the following registers itself:
- the line control register;
- the 16-bit baud divisor;
- the scratchpad byte;
- the flow-control feature byte;
- the four flow-control character bytes.

The transmit/receive data path, the interrupt enable and status registers, the FIFO control, the modem control and the two status registers live in neighbouring blocks. For those, the decoder issues one-cycle strobes and muxes their values onto the read bus. A write strobe tells its neighbour to capture `wrData` on the same clock edge.

All strobes and `rdData` are combinational from the current address, the enables and the registered bank state. Writes to held registers take effect at the rising clock edge.

Top module: `uart_bank_decoder`

## Requirements
- R1: After synchronous active-low reset, every held register is zero, so the general bank is selected. `lcrOut`, `divisorOut`, `efrOut`, `xon1Out`, `xon2Out`, `xoff1Out`, `xoff2Out` and the scratchpad read 0.
- R2: Bank selection depends on the line control register:
  - If LCR is exactly 0xBF, the enhanced bank is selected.
  - Otherwise, if LCR bit 7 is 1, the divisor bank is selected.
  - Otherwise, the general bank is selected.
  
  In the general bank, a read with `rdEn` returns:
  - address 0: `rhrIn`
  - address 1: `ierIn`
  - address 2: `isrIn`
  - address 3: LCR
  - address 4: `mcrIn`
  - address 5: `lsrIn`
  - address 6: `msrIn`
  - address 7: the scratchpad
- R3: In the general bank, `wrEn` produces exactly one write strobe in that cycle:
  - address 0: `txPush`
  - address 1: `ierWr`
  - address 2: `fcrWr`
  - address 4: `mcrWr`
- R4: Read strobes are high only in a cycle with `rdEn`:
  - `rxPop` for address 0 in the general bank
  - `isrRd` for address 2 outside the enhanced bank
  - `lsrRd` for address 5 outside the enhanced bank
  - `msrRd` for address 6 outside the enhanced bank
  
  With `rdEn` low, `rdData` is 0 and no read strobe is high.
- R5: In the general and divisor banks, a write to address 5 or 6 raises no strobe and changes no held register.
- R6: Whenever LCR bit 7 is 1 (divisor and enhanced banks), address 0 reads and writes the divisor low byte and address 1 the divisor high byte. `divisorOut` is {high, low}. No `txPush`, `rxPop` or `ierWr` is raised.
- R7: In the divisor bank, addresses 2 and 4 to 7 behave as in the general bank.
- R8: In the enhanced bank, the following addresses read and write held registers: 2 the feature byte, 4 Xon1, 5 Xon2, 6 Xoff1, 7 Xoff2. None of `fcrWr`, `mcrWr`, `isrRd`, `lsrRd` or `msrRd` is raised.
- R9: Address 3 reads and writes LCR in every bank. The new bank applies from the cycle after the write.
- R10: The 0xBF match overrides the plain bit-7 test. Values 0x80, 0xBE and 0xFF select the divisor bank, not the enhanced bank.
- R11: The scratchpad holds the last byte written to it and affects no other output.
- R12: A write to a held register changes its output port and its read-back only after the rising clock edge. In the write cycle the old value is still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register address |
| rdEn | input | 1 | Read enable, one cycle per access |
| wrEn | input | 1 | Write enable, one cycle per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0 when no read |
| rhrIn | input | 8 | Head of receive FIFO |
| ierIn | input | 8 | Interrupt enable value |
| isrIn | input | 8 | Interrupt status value |
| mcrIn | input | 8 | Modem control value |
| lsrIn | input | 8 | Line status value |
| msrIn | input | 8 | Modem status value |
| txPush | output | 1 | Push `wrData` into transmit FIFO |
| rxPop | output | 1 | Pop receive FIFO |
| ierWr | output | 1 | Load interrupt enable |
| fcrWr | output | 1 | Load FIFO control |
| mcrWr | output | 1 | Load modem control |
| isrRd | output | 1 | Interrupt status was read |
| lsrRd | output | 1 | Line status was read |
| msrRd | output | 1 | Modem status was read |
| lcrOut | output | 8 | Line control register |
| divisorOut | output | 16 | Baud divisor |
| efrOut | output | 8 | Flow-control feature byte |
| xon1Out | output | 8 | First Xon character |
| xon2Out | output | 8 | Second Xon character |
| xoff1Out | output | 8 | First Xoff character |
| xoff2Out | output | 8 | Second Xoff character |

## Verification
Strobes and `rdData` are due in the same cycle as the enable. The bench drives each access on the falling edge and samples one nanosecond later, before the rising edge. Held-register outputs are due one cycle later. The bench therefore compares them twice:
- once before the edge, against the old model value (R12);
- once just after the edge, against the updated model.

Every address is swept, for reads and for writes, under ten LCR values that cover all three banks and the priority boundary.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 3;
  parameter int FLOW_N  = 4;
  parameter logic [DATA_W-1:0] ENH_KEY = 8'hBF;
  localparam int DIV_W  = 2 * DATA_W;

  typedef enum logic [1:0] {BANK_GEN, BANK_DIV, BANK_ENH} bank_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RHR, SEL_IER, SEL_ISR, SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR,
    SEL_SPR, SEL_DLL, SEL_DLM, SEL_EFR, SEL_FLOW0, SEL_FLOW1, SEL_FLOW2, SEL_FLOW3
  } rdSel_e;

  typedef struct packed {
    logic              lcr;
    logic              dll;
    logic              dlm;
    logic              spr;
    logic              efr;
    logic [FLOW_N-1:0] flow;
  } regWr_t;

  typedef struct packed {
    logic txPush;
    logic ierWr;
    logic fcrWr;
    logic mcrWr;
    logic rxPop;
    logic isrRd;
    logic lsrRd;
    logic msrRd;
  } extStb_t;

  typedef struct packed {
    regWr_t  wr;
    extStb_t ext;
    rdSel_e  sel;
  } ctrlStb_t;
endpackage

// File: rtl/uart_bank_ctrl.sv
module uart_bank_ctrl
  import uart_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  bank_e             bank,
  output ctrlStb_t          stb
);
  logic enh;
  logic dlab;

  assign enh  = (bank == BANK_ENH);
  assign dlab = (bank != BANK_GEN);

  always_comb begin
    stb = '0;
    stb.sel = SEL_NONE;
    unique case (addr)
      3'd0: begin
        if (dlab) begin
          stb.wr.dll = wrEn;
          if (rdEn) stb.sel = SEL_DLL;
        end else begin
          stb.ext.txPush = wrEn;
          stb.ext.rxPop  = rdEn;
          if (rdEn) stb.sel = SEL_RHR;
        end
      end
      3'd1: begin
        if (dlab) begin
          stb.wr.dlm = wrEn;
          if (rdEn) stb.sel = SEL_DLM;
        end else begin
          stb.ext.ierWr = wrEn;
          if (rdEn) stb.sel = SEL_IER;
        end
      end
      3'd2: begin
        if (enh) begin
          stb.wr.efr = wrEn;
          if (rdEn) stb.sel = SEL_EFR;
        end else begin
          stb.ext.fcrWr = wrEn;
          stb.ext.isrRd = rdEn;
          if (rdEn) stb.sel = SEL_ISR;
        end
      end
      3'd3: begin
        stb.wr.lcr = wrEn;
        if (rdEn) stb.sel = SEL_LCR;
      end
      3'd4: begin
        if (enh) begin
          stb.wr.flow[0] = wrEn;
          if (rdEn) stb.sel = SEL_FLOW0;
        end else begin
          stb.ext.mcrWr = wrEn;
          if (rdEn) stb.sel = SEL_MCR;
        end
      end
      3'd5: begin
        if (enh) begin
          stb.wr.flow[1] = wrEn;
          if (rdEn) stb.sel = SEL_FLOW1;
        end else begin
          stb.ext.lsrRd = rdEn;
          if (rdEn) stb.sel = SEL_LSR;
        end
      end
      3'd6: begin
        if (enh) begin
          stb.wr.flow[2] = wrEn;
          if (rdEn) stb.sel = SEL_FLOW2;
        end else begin
          stb.ext.msrRd = rdEn;
          if (rdEn) stb.sel = SEL_MSR;
        end
      end
      default: begin
        if (enh) begin
          stb.wr.flow[3] = wrEn;
          if (rdEn) stb.sel = SEL_FLOW3;
        end else begin
          stb.wr.spr = wrEn;
          if (rdEn) stb.sel = SEL_SPR;
        end
      end
    endcase
  end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  regWr_t            wr,
  input  rdSel_e            sel,
  input  logic [DATA_W-1:0] rhrIn,
  input  logic [DATA_W-1:0] ierIn,
  input  logic [DATA_W-1:0] isrIn,
  input  logic [DATA_W-1:0] mcrIn,
  input  logic [DATA_W-1:0] lsrIn,
  input  logic [DATA_W-1:0] msrIn,
  output logic [DATA_W-1:0] rdData,
  output bank_e             bank,
  output logic [DATA_W-1:0] lcrQ,
  output logic [DIV_W-1:0]  divQ,
  output logic [DATA_W-1:0] efrQ,
  output logic [DATA_W-1:0] flowQ [FLOW_N]
);
  logic [DATA_W-1:0] sprQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrQ <= '0;
      divQ <= '0;
      sprQ <= '0;
      efrQ <= '0;
    end else begin
      if (wr.lcr) lcrQ <= wrData;
      if (wr.dll) divQ[DATA_W-1:0] <= wrData;
      if (wr.dlm) divQ[DIV_W-1:DATA_W] <= wrData;
      if (wr.spr) sprQ <= wrData;
      if (wr.efr) efrQ <= wrData;
    end
  end

  for (genvar i = 0; i < FLOW_N; i++) begin : g_flow
    always_ff @(posedge clk) begin
      if (!rstN)          flowQ[i] <= '0;
      else if (wr.flow[i]) flowQ[i] <= wrData;
    end
  end

  always_comb begin
    if (lcrQ == ENH_KEY)         bank = BANK_ENH;
    else if (lcrQ[DATA_W-1])     bank = BANK_DIV;
    else                         bank = BANK_GEN;
  end

  always_comb begin
    unique case (sel)
      SEL_RHR:   rdData = rhrIn;
      SEL_IER:   rdData = ierIn;
      SEL_ISR:   rdData = isrIn;
      SEL_LCR:   rdData = lcrQ;
      SEL_MCR:   rdData = mcrIn;
      SEL_LSR:   rdData = lsrIn;
      SEL_MSR:   rdData = msrIn;
      SEL_SPR:   rdData = sprQ;
      SEL_DLL:   rdData = divQ[DATA_W-1:0];
      SEL_DLM:   rdData = divQ[DIV_W-1:DATA_W];
      SEL_EFR:   rdData = efrQ;
      SEL_FLOW0: rdData = flowQ[0];
      SEL_FLOW1: rdData = flowQ[1];
      SEL_FLOW2: rdData = flowQ[2];
      SEL_FLOW3: rdData = flowQ[3];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_bank_decoder.sv
module uart_bank_decoder
  import uart_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [DATA_W-1:0]    rhrIn,
  input  logic [DATA_W-1:0]    ierIn,
  input  logic [DATA_W-1:0]    isrIn,
  input  logic [DATA_W-1:0]    mcrIn,
  input  logic [DATA_W-1:0]    lsrIn,
  input  logic [DATA_W-1:0]    msrIn,
  output logic                 txPush,
  output logic                 rxPop,
  output logic                 ierWr,
  output logic                 fcrWr,
  output logic                 mcrWr,
  output logic                 isrRd,
  output logic                 lsrRd,
  output logic                 msrRd,
  output logic [DATA_W-1:0]    lcrOut,
  output logic [DIV_W-1:0]     divisorOut,
  output logic [DATA_W-1:0]    efrOut,
  output logic [DATA_W-1:0]    xon1Out,
  output logic [DATA_W-1:0]    xon2Out,
  output logic [DATA_W-1:0]    xoff1Out,
  output logic [DATA_W-1:0]    xoff2Out
);
  ctrlStb_t          stb;
  bank_e             bank;
  logic [DATA_W-1:0] flowQ [FLOW_N];

  uart_bank_ctrl u_ctrl (
    .addr (addr),
    .rdEn (rdEn),
    .wrEn (wrEn),
    .bank (bank),
    .stb  (stb)
  );

  uart_bank_regs u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrData (wrData),
    .wr     (stb.wr),
    .sel    (stb.sel),
    .rhrIn  (rhrIn),
    .ierIn  (ierIn),
    .isrIn  (isrIn),
    .mcrIn  (mcrIn),
    .lsrIn  (lsrIn),
    .msrIn  (msrIn),
    .rdData (rdData),
    .bank   (bank),
    .lcrQ   (lcrOut),
    .divQ   (divisorOut),
    .efrQ   (efrOut),
    .flowQ  (flowQ)
  );

  assign txPush   = stb.ext.txPush;
  assign rxPop    = stb.ext.rxPop;
  assign ierWr    = stb.ext.ierWr;
  assign fcrWr    = stb.ext.fcrWr;
  assign mcrWr    = stb.ext.mcrWr;
  assign isrRd    = stb.ext.isrRd;
  assign lsrRd    = stb.ext.lsrRd;
  assign msrRd    = stb.ext.msrRd;
  assign xon1Out  = flowQ[0];
  assign xon2Out  = flowQ[1];
  assign xoff1Out = flowQ[2];
  assign xoff2Out = flowQ[3];
endmodule

// File: rtl/uart_bank_decoder_chk.sv
module uart_bank_decoder_chk
  import uart_bank_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              txPush,
  input logic              rxPop,
  input logic              ierWr,
  input logic              fcrWr,
  input logic              mcrWr,
  input logic              isrRd,
  input logic              lsrRd,
  input logic              msrRd,
  input logic [DATA_W-1:0] lcrOut,
  input logic [DIV_W-1:0]  divisorOut
);
  logic inEnh;
  logic inGen;
  assign inEnh = (lcrOut == ENH_KEY);
  assign inGen = !lcrOut[DATA_W-1];

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (lcrOut == '0 && divisorOut == '0));

  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txPush, ierWr, fcrWr, mcrWr}));

  p_rd_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> ({rxPop, isrRd, lsrRd, msrRd} == 4'b0 && rdData == '0));

  p_status_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !inEnh && (addr == 3'd5 || addr == 3'd6))
      |-> ({txPush, ierWr, fcrWr, mcrWr} == 4'b0));

  p_status_wr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inEnh && (addr == 3'd5 || addr == 3'd6))
      |=> ($stable(lcrOut) && $stable(divisorOut)));

  p_div_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !inGen && addr == 3'd0)
      |=> divisorOut[DATA_W-1:0] == $past(wrData));

  p_enh_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    inEnh |-> ({fcrWr, mcrWr, isrRd, lsrRd, msrRd, txPush, rxPop, ierWr} == 8'b0));

  p_lcr_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=> lcrOut == $past(wrData));
endmodule

bind uart_bank_decoder uart_bank_decoder_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addr       (addr),
  .rdEn       (rdEn),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .txPush     (txPush),
  .rxPop      (rxPop),
  .ierWr      (ierWr),
  .fcrWr      (fcrWr),
  .mcrWr      (mcrWr),
  .isrRd      (isrRd),
  .lsrRd      (lsrRd),
  .msrRd      (msrRd),
  .lcrOut     (lcrOut),
  .divisorOut (divisorOut)
);

// File: tb/uart_bank_decoder_tb.sv
module uart_bank_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [7:0]  rhrIn = 8'h11, ierIn = 8'h22, isrIn = 8'h33;
  logic [7:0]  mcrIn = 8'h44, lsrIn = 8'h55, msrIn = 8'h66;
  logic        txPush, rxPop, ierWr, fcrWr, mcrWr, isrRd, lsrRd, msrRd;
  logic [7:0]  lcrOut, efrOut, xon1Out, xon2Out, xoff1Out, xoff2Out;
  logic [15:0] divisorOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] mLcr, mDll, mDlm, mSpr, mEfr;
  logic [7:0] mFlow [4];

  always #2 clk = ~clk;

  uart_bank_decoder u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData),
    .rhrIn(rhrIn), .ierIn(ierIn), .isrIn(isrIn), .mcrIn(mcrIn),
    .lsrIn(lsrIn), .msrIn(msrIn),
    .txPush(txPush), .rxPop(rxPop), .ierWr(ierWr), .fcrWr(fcrWr),
    .mcrWr(mcrWr), .isrRd(isrRd), .lsrRd(lsrRd), .msrRd(msrRd),
    .lcrOut(lcrOut), .divisorOut(divisorOut), .efrOut(efrOut),
    .xon1Out(xon1Out), .xon2Out(xon2Out), .xoff1Out(xoff1Out),
    .xoff2Out(xoff2Out)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int bankOf(input logic [7:0] l);
    if (l == 8'hBF) return 2;
    if (l[7])       return 1;
    return 0;
  endfunction

  task automatic chkHeld(input string tag);
    chk(tag, "lcrOut",     lcrOut,     mLcr);
    chk(tag, "divisorOut", divisorOut, {mDlm, mDll});
    chk(tag, "efrOut",     efrOut,     mEfr);
    chk(tag, "xon1Out",    xon1Out,    mFlow[0]);
    chk(tag, "xon2Out",    xon2Out,    mFlow[1]);
    chk(tag, "xoff1Out",   xoff1Out,   mFlow[2]);
    chk(tag, "xoff2Out",   xoff2Out,   mFlow[3]);
  endtask

  // one access: drive at falling edge, check combinational results, then edge
  task automatic access(input bit isWr, input logic [2:0] a, input logic [7:0] d,
                        input string tagOvr);
    int   b = bankOf(mLcr);
    logic [3:0] expWr = '0;  // {txPush, ierWr, fcrWr, mcrWr}
    logic [3:0] expRd = '0;  // {rxPop, isrRd, lsrRd, msrRd}
    logic [7:0] expData = '0;
    string tag;
    if (isWr) begin
      if (a == 3)                    tag = "R9";
      else if (b == 2 && a >= 2)     tag = "R8";
      else if (b != 0 && a < 2)      tag = "R6";
      else if (b == 1)               tag = "R7";
      else if (a == 5 || a == 6)     tag = "R5";
      else if (a == 7)               tag = "R11";
      else                           tag = "R3";
    end else begin
      if (a == 3)                    tag = "R9";
      else if (b == 2 && a >= 2)     tag = "R8";
      else if (b != 0 && a < 2)      tag = "R6";
      else if (b == 1)               tag = "R7";
      else                           tag = "R2";
    end
    if (tagOvr != "") tag = tagOvr;
    if (!isWr) begin
      case (a)
        3'd0: if (b == 0) begin expData = rhrIn; expRd = 4'b1000; end else expData = mDll;
        3'd1: expData = (b == 0) ? ierIn : mDlm;
        3'd2: if (b == 2) expData = mEfr; else begin expData = isrIn; expRd = 4'b0100; end
        3'd3: expData = mLcr;
        3'd4: expData = (b == 2) ? mFlow[0] : mcrIn;
        3'd5: if (b == 2) expData = mFlow[1]; else begin expData = lsrIn; expRd = 4'b0010; end
        3'd6: if (b == 2) expData = mFlow[2]; else begin expData = msrIn; expRd = 4'b0001; end
        default: expData = (b == 2) ? mFlow[3] : mSpr;
      endcase
    end else begin
      if (a == 0 && b == 0) expWr = 4'b1000;
      if (a == 1 && b == 0) expWr = 4'b0100;
      if (a == 2 && b != 2) expWr = 4'b0010;
      if (a == 4 && b != 2) expWr = 4'b0001;
    end
    @(negedge clk);
    addr = a; wrData = d; wrEn = isWr; rdEn = !isWr;
    #1;
    chk(tag, "rdData", rdData, expData);
    chk(isWr ? tag : "R4", "write strobes", {txPush, ierWr, fcrWr, mcrWr}, expWr);
    chk(isWr ? "R5" : tag, "read strobes", {rxPop, isrRd, lsrRd, msrRd}, expRd);
    chkHeld("R12");
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
    if (isWr) begin
      case (a)
        3'd0: if (b != 0) mDll = d;
        3'd1: if (b != 0) mDlm = d;
        3'd2: if (b == 2) mEfr = d;
        3'd3: mLcr = d;
        3'd4: if (b == 2) mFlow[0] = d;
        3'd5: if (b == 2) mFlow[1] = d;
        3'd6: if (b == 2) mFlow[2] = d;
        default: if (b == 2) mFlow[3] = d; else mSpr = d;
      endcase
    end
    chkHeld(tag);
  endtask

  logic [7:0] lcrList [10] = '{8'h00, 8'h03, 8'h80, 8'h8F, 8'hBE,
                               8'hBF, 8'hFF, 8'h3B, 8'hBF, 8'h00};

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    mLcr = '0; mDll = '0; mDlm = '0; mSpr = '0; mEfr = '0;
    for (int i = 0; i < 4; i++) mFlow[i] = '0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset values, scratchpad read back
    chkHeld("R1");
    access(1'b0, 3'd7, 8'h00, "R1");
    // R4: idle cycle with no enables
    @(negedge clk); addr = 3'd0; #1;
    chk("R4", "idle rdData", rdData, 8'h00);
    chk("R4", "idle read strobes", {rxPop, isrRd, lsrRd, msrRd}, 4'b0);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] l = lcrList[k];
      access(1'b1, 3'd3, l,
             (l == 8'h80 || l == 8'hBE || l == 8'hFF || l == 8'hBF) ? "R10" : "R9");
      for (int a = 0; a < 8; a++) begin
        if (a != 3) access(1'b1, 3'(a), 8'(k * 37 + a * 13 + 5), "");
      end
      for (int a = 0; a < 8; a++) begin
        access(1'b0, 3'(a), 8'h00, "");
      end
    end
    // R11: scratchpad keeps value across bank switches and status writes
    access(1'b1, 3'd7, 8'hA5, "R11");
    access(1'b1, 3'd5, 8'h5A, "R5");
    access(1'b1, 3'd6, 8'hC3, "R5");
    access(1'b1, 3'd3, 8'hBF, "R10");
    access(1'b1, 3'd3, 8'h00, "R9");
    access(1'b0, 3'd7, 8'h00, "R11");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule